// File: doc/BRIEF.md
# Key-Code Committed Control Register Unit

This block is a small register file on a simple 8-bit register bus that protects system configuration bits against accidental change. Software first writes the wanted values into a staging register. They reach the outputs that the rest of the chip uses only when a matching unlock byte is written to a separate command port. There is one unlock byte for the reset-pin-disable bit and another for the two remap bits, which move together.

The command port is write-only. A read from its address returns a status view of the committed bits instead. The committed reset-pin-disable bit is cleared only by power-on reset, because an ordinary reset must not turn a disabled reset pin back on. The block also records which internal events caused a reset, in seven sticky flags. Clearing those flags takes two steps: software arms a clear request, then writes a third unlock byte.

Top module: `keyed_cfg_regs`

## Requirements
- R1: A write to the staging address (default 0) stores bits 2:0: bit 0 reset-pin disable, bit 1 remap area, bit 2 remap vector. A read of that address returns those bits with bits 7:3 as 0. Staged values do not change the committed outputs.
- R2: Writing 0xB2 to the command address (default 1) copies staged bit 0 into `pin_rst_dis` at the next clock edge. The remap outputs are left unchanged.
- R3: Writing 0xD4 to the command address copies staged bits 1 and 2 into `remap_area` and `remap_vec` together at the next clock edge. `pin_rst_dis` is left unchanged.
- R4: Any other byte written to the command address leaves all three committed outputs unchanged.
- R5: A read of the command address returns the status view, not the written byte. Bit 0 is `pin_rst_dis`, bit 1 is `remap_area`, bit 2 is `remap_vec`, and bits 7:3 are 0.
- R6: `rst_n` low clears the staging register, the clear request and both remap outputs, and keeps `pin_rst_dis` and the cause flags. `por_n` low clears everything, including `pin_rst_dis` and the flags.
- R7: A one-cycle pulse on `cause_set[i]` sets flag i, and the flag stays set until a keyed clear or power-on reset. At the cause address (default 2), bits 6:0 read as: 6 flash, 5 trimming status, 4 trimming, 3 voltage-detect 2, 2 voltage-detect 1, 1 system, 0 watchdog. Bit 7 reads 0, and bus writes never change the flags.
- R8: Writing a byte with bit 7 set to the cause address arms a clear request. The next 0x71 write to the command port clears all flags and consumes the request. A 0x71 write with no armed request changes no flag.
- R9: `rdata` is 0 when `rd_en` is low or when the address is not mapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_n | input | 1 | Ordinary reset, active low, asynchronous |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data |
| cause_set | input | 7 | One-cycle set pulses for the reset-cause flags |
| pin_rst_dis | output | 1 | Committed reset-pin disable |
| remap_area | output | 1 | Committed remap area |
| remap_vec | output | 1 | Committed remap vector |

## Verification
The hardest state to reach is a committed reset-pin disable that has outlived an ordinary reset while the staging register next to it has been wiped. This state exists only after a commit followed by a reset pulse in mid-run. The bench commits the bit and then pulses `rst_n` alone. It then reads the staging register and the status view, expecting 0 and 0x01. The two-step clear is driven the same way: a 0x71 write without a request first, then one after arming, then a second 0x71 without rearming. This shows that the request is used up.

// File: rtl/keyed_cfg_regs.sv
module keyed_cfg_regs #(
  parameter int unsigned ADDR_W = 4,
  parameter logic [ADDR_W-1:0] STAGE_ADDR = 4'h0,
  parameter logic [ADDR_W-1:0] CMD_ADDR   = 4'h1,
  parameter logic [ADDR_W-1:0] CAUSE_ADDR = 4'h2,
  parameter logic [7:0] KEY_PIN   = 8'hB2,
  parameter logic [7:0] KEY_REMAP = 8'hD4,
  parameter logic [7:0] KEY_CLR   = 8'h71
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [6:0]        cause_set,
  output logic              pin_rst_dis,
  output logic              remap_area,
  output logic              remap_vec
);

  logic       sys_rst_n;
  logic [2:0] stage;
  logic [6:0] flags;
  logic       clr_arm;
  logic       cmd_wr, stage_wr, cause_wr, clr_fire;

  assign sys_rst_n = por_n & rst_n;
  assign stage_wr  = wr_en && (addr == STAGE_ADDR);
  assign cmd_wr    = wr_en && (addr == CMD_ADDR);
  assign cause_wr  = wr_en && (addr == CAUSE_ADDR);
  assign clr_fire  = cmd_wr && (wdata == KEY_CLR) && clr_arm;

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      stage      <= '0;
      remap_area <= 1'b0;
      remap_vec  <= 1'b0;
      clr_arm    <= 1'b0;
    end else begin
      if (stage_wr) stage <= wdata[2:0];
      if (cmd_wr && wdata == KEY_REMAP) begin
        remap_area <= stage[1];
        remap_vec  <= stage[2];
      end
      if (clr_fire) clr_arm <= 1'b0;
      else if (cause_wr && wdata[7]) clr_arm <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pin_rst_dis <= 1'b0;
      flags       <= '0;
    end else begin
      if (cmd_wr && wdata == KEY_PIN) pin_rst_dis <= stage[0];
      flags <= (clr_fire ? 7'd0 : flags) | cause_set;
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (rd_en) begin
      if (addr == STAGE_ADDR)      rdata = {5'b0, stage};
      else if (addr == CMD_ADDR)   rdata = {5'b0, remap_vec, remap_area, pin_rst_dis};
      else if (addr == CAUSE_ADDR) rdata = {1'b0, flags};
    end
  end

  assert_pin_commit_R2: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (cmd_wr && wdata == KEY_PIN) |=> (pin_rst_dis == $past(stage[0])));

  assert_remap_commit_R3: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (cmd_wr && wdata == KEY_REMAP) |=> ({remap_vec, remap_area} == $past(stage[2:1])));

  assert_bad_key_R4: assert property (@(posedge clk) disable iff (!sys_rst_n)
    !(cmd_wr && (wdata == KEY_PIN || wdata == KEY_REMAP))
      |=> $stable({pin_rst_dis, remap_area, remap_vec}));

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!sys_rst_n)
    !clr_fire |=> ((flags & $past(flags)) == $past(flags)));

  assert_keyed_clear_R8: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (clr_fire && cause_set == 7'd0) |=> (flags == 7'd0 && !clr_arm));

  always_comb begin
    if (!rd_en) assert_idle_read_R9: assert (rdata == 8'h00);
  end

endmodule

// File: tb/keyed_cfg_regs_tb.sv
module keyed_cfg_regs_tb;
  logic       clk = 1'b0;
  logic       por_n = 1'b0, rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [6:0] cause_set = '0;
  logic       pin_rst_dis, remap_area, remap_vec;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  localparam logic [3:0] A_STG = 4'h0, A_CMD = 4'h1, A_CAU = 4'h2, A_NONE = 4'hF;

  always #2 clk = ~clk;

  keyed_cfg_regs u_dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .cause_set(cause_set),
    .pin_rst_dis(pin_rst_dis), .remap_area(remap_area), .remap_vec(remap_vec)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic pulse(input logic [6:0] m);
    @(negedge clk);
    cause_set = m;
    @(negedge clk);
    cause_set = '0;
  endtask

  function automatic logic [7:0] outs();
    return {5'b0, remap_vec, remap_area, pin_rst_dis};
  endfunction

  task automatic t_reset_state();
    logic [7:0] d;
    check("R6 outputs after por", outs(), 8'h00);
    rd(A_STG, d); check("R6 stage after por", d, 8'h00);
    rd(A_CAU, d); check("R6 flags after por", d, 8'h00);
  endtask

  task automatic t_stage();
    logic [7:0] d;
    wr(A_STG, 8'hFF);
    rd(A_STG, d); check("R1 stage readback", d, 8'h07);
    check("R1 staged not committed", outs(), 8'h00);
    rd(A_CMD, d); check("R5 status uncommitted", d, 8'h00);
  endtask

  task automatic t_bad_keys();
    logic [7:0] d;
    logic [7:0] bad [5] = '{8'h00, 8'hB3, 8'hD5, 8'h70, 8'hFF};
    foreach (bad[i]) begin
      wr(A_CMD, bad[i]);
      check("R4 bad key ignored", outs(), 8'h00);
    end
    rd(A_CMD, d); check("R5 status not written byte", d, 8'h00);
  endtask

  task automatic t_pin_commit();
    logic [7:0] d;
    wr(A_CMD, 8'hB2);
    check("R2 pin commit only", outs(), 8'h01);
    rd(A_CMD, d); check("R5 status pin", d, 8'h01);
  endtask

  task automatic t_remap_commit();
    logic [7:0] d;
    wr(A_STG, 8'h02);
    wr(A_CMD, 8'hD4);
    check("R3 remap area commit", outs(), 8'h03);
    wr(A_STG, 8'h04);
    wr(A_CMD, 8'hD4);
    rd(A_CMD, d); check("R3 remap vec commit status", d, 8'h05);
    check("R2 pin kept after stage bit0=0 without B2", outs(), 8'h05);
  endtask

  task automatic t_ordinary_reset();
    logic [7:0] d;
    pulse(7'h02);
    wr(A_CAU, 8'h80);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(A_STG, d); check("R6 stage cleared by rst", d, 8'h00);
    rd(A_CMD, d); check("R6 pin survives rst", d, 8'h01);
    rd(A_CAU, d); check("R6 flags survive rst", d, 8'h02);
    wr(A_CMD, 8'h71);
    rd(A_CAU, d); check("R6 arm cleared by rst", d, 8'h02);
  endtask

  task automatic t_flags();
    logic [7:0] d;
    logic [7:0] exp = 8'h02;
    for (int i = 0; i < 7; i++) begin
      pulse(7'(1 << i));
      exp |= 8'(1 << i);
      rd(A_CAU, d); check("R7 flag accumulate", d, exp);
    end
    wr(A_CAU, 8'h00);
    rd(A_CAU, d); check("R7 flags read-only, bit7 zero", d, 8'h7F);
  endtask

  task automatic t_clear();
    logic [7:0] d;
    wr(A_CMD, 8'h71);
    rd(A_CAU, d); check("R8 unarmed clear ignored", d, 8'h7F);
    wr(A_CAU, 8'h80);
    rd(A_CAU, d); check("R8 arm bit reads 0", d, 8'h7F);
    wr(A_CMD, 8'h71);
    rd(A_CAU, d); check("R8 armed clear", d, 8'h00);
    pulse(7'h41);
    wr(A_CMD, 8'h71);
    rd(A_CAU, d); check("R8 request consumed", d, 8'h41);
    check("R4 clear key keeps committed", outs(), 8'h01);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    rd(A_NONE, d); check("R9 unmapped read", d, 8'h00);
    @(negedge clk); addr = A_CMD; rd_en = 1'b0;
    #1 check("R9 no strobe read", rdata, 8'h00);
  endtask

  task automatic t_por();
    logic [7:0] d;
    wr(A_STG, 8'h07);
    wr(A_CMD, 8'hD4);
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    check("R6 por clears committed", outs(), 8'h00);
    rd(A_CAU, d); check("R6 por clears flags", d, 8'h00);
    rd(A_STG, d); check("R6 por clears stage", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    t_reset_state();
    t_stage();
    t_bad_keys();
    t_pin_commit();
    t_remap_commit();
    t_ordinary_reset();
    t_flags();
    t_clear();
    t_unmapped();
    t_por();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule